// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits on the command side of a synchronous DRAM device model. On every rising clock edge it samples chip select, the three command strobes (row, column, write-enable, all active low), a two-bit bank address and an 11-bit address. It turns them into one decoded strobe per cycle, together with the bank, the full address (row or op-code) and the column field. It also raises flags for auto-precharge, precharge-all and extended mode register select.

For each of four banks it records whether a row is open and which row that is. ACTIVE, PRECHARGE and auto-precharging accesses update this state. A read or write aimed at a bank with no open row does not produce an access strobe. It produces a one-cycle error pulse instead. All decoded outputs are registered, so they appear one cycle after the edge that sampled the command. Timing-parameter checks, power-down and self refresh are not part of this block.

Top module: `sdram_cmd_decode`

## Requirements
- R1: While reset is asserted, and until the first post-reset edge has sampled a command, every strobe and flag is low, every bank is closed and every tracked row is zero.
- R2: Inputs are sampled only on the rising clock edge. Decoded outputs and bank state change on that same edge and hold until the next one.
- R3: With chip select high at the edge, only the deselect strobe is raised and no bank state changes, whatever the other inputs are.
- R4: With chip select low, {ras_n,cas_n,we_n} decodes as follows: 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 AUTO REFRESH, 110 BURST TERMINATE, 000 LOAD MODE. At most one strobe is high in any cycle.
- R5: ACTIVE opens bank ba and stores addr[10:0] as its row. bank_out shows ba and addr_out shows the row.
- R6: READ or WRITE to an open bank raises its strobe. col_out is addr[7:0] and auto_pre is addr[8]. With addr[8] low, the bank stays open.
- R7: READ or WRITE to an open bank with addr[8] high closes that bank at the same edge.
- R8: PRECHARGE with addr[8] low closes only bank ba, and pre_all is low.
- R9: PRECHARGE with addr[8] high closes all four banks, and pre_all is high.
- R10: LOAD MODE raises its strobe with the op-code on addr_out. mode_ext is ba[0] (0 = mode register, 1 = extended). Bank state is unchanged.
- R11: READ or WRITE to a closed bank raises err_closed for one cycle, raises no read or write strobe and leaves auto_pre low. Bank state is unchanged.
- R12: NOP, AUTO REFRESH and BURST TERMINATE leave bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Address / op-code |
| cmd_desel | output | 1 | Deselect decoded |
| cmd_nop | output | 1 | NOP decoded |
| cmd_act | output | 1 | ACTIVE decoded |
| cmd_rd | output | 1 | READ to open bank |
| cmd_wr | output | 1 | WRITE to open bank |
| cmd_pre | output | 1 | PRECHARGE decoded |
| cmd_ref | output | 1 | AUTO REFRESH decoded |
| cmd_bst | output | 1 | BURST TERMINATE decoded |
| cmd_lmr | output | 1 | LOAD MODE decoded |
| err_closed | output | 1 | READ/WRITE to a closed bank |
| bank_out | output | 2 | Sampled bank address |
| addr_out | output | 11 | Sampled address (row or op-code) |
| col_out | output | 8 | Sampled column field |
| auto_pre | output | 1 | Auto-precharge on an access |
| pre_all | output | 1 | Precharge of all banks |
| mode_ext | output | 1 | Extended mode register selected |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 44 | Tracked rows, bank i at bits [11i+10:11i] |

## Verification
The directed part opens banks with distinct rows, then accesses each one with and without auto-precharge. This separates precharge of a single bank from precharge of all banks, and it catches a write whose error check looks at the wrong bank. Reads and writes to closed banks follow ACTIVE, PRECHARGE and auto-precharge, so the bench can tell error detection apart from stale state. Chip select high combined with every command code shows that deselect masks the code fully. A long random stream of codes, banks and addresses is then compared every cycle against a behavioural bank model, and this exposes wrong encodings or bit positions.

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int BANKS  = 4,
  parameter int AP_BIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [1:0]               ba,
  input  logic [10:0]              addr,
  output logic                     cmd_desel,
  output logic                     cmd_nop,
  output logic                     cmd_act,
  output logic                     cmd_rd,
  output logic                     cmd_wr,
  output logic                     cmd_pre,
  output logic                     cmd_ref,
  output logic                     cmd_bst,
  output logic                     cmd_lmr,
  output logic                     err_closed,
  output logic [1:0]               bank_out,
  output logic [10:0]              addr_out,
  output logic [7:0]               col_out,
  output logic                     auto_pre,
  output logic                     pre_all,
  output logic                     mode_ext,
  output logic [3:0]               bank_open,
  output logic [43:0]              open_rows
);
  localparam int BA_W = $clog2(BANKS);

  logic [ROW_W-1:0] rows [BANKS];
  logic [2:0] code;
  assign code = {ras_n, cas_n, we_n};

  wire is_nop = !cs_n && code == 3'b111;
  wire is_act = !cs_n && code == 3'b011;
  wire is_rd  = !cs_n && code == 3'b101;
  wire is_wr  = !cs_n && code == 3'b100;
  wire is_pre = !cs_n && code == 3'b010;
  wire is_ref = !cs_n && code == 3'b001;
  wire is_bst = !cs_n && code == 3'b110;
  wire is_lmr = !cs_n && code == 3'b000;

  wire sel_open = bank_open[ba[BA_W-1:0]];
  wire access   = (is_rd || is_wr) && sel_open;
  wire ap       = addr[AP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_desel  <= 1'b0;
      cmd_nop    <= 1'b0;
      cmd_act    <= 1'b0;
      cmd_rd     <= 1'b0;
      cmd_wr     <= 1'b0;
      cmd_pre    <= 1'b0;
      cmd_ref    <= 1'b0;
      cmd_bst    <= 1'b0;
      cmd_lmr    <= 1'b0;
      err_closed <= 1'b0;
      bank_out   <= '0;
      addr_out   <= '0;
      col_out    <= '0;
      auto_pre   <= 1'b0;
      pre_all    <= 1'b0;
      mode_ext   <= 1'b0;
    end else begin
      cmd_desel  <= cs_n;
      cmd_nop    <= is_nop;
      cmd_act    <= is_act;
      cmd_rd     <= is_rd && sel_open;
      cmd_wr     <= is_wr && sel_open;
      cmd_pre    <= is_pre;
      cmd_ref    <= is_ref;
      cmd_bst    <= is_bst;
      cmd_lmr    <= is_lmr;
      err_closed <= (is_rd || is_wr) && !sel_open;
      bank_out   <= ba;
      addr_out   <= addr;
      col_out    <= addr[COL_W-1:0];
      auto_pre   <= access && ap;
      pre_all    <= is_pre && ap;
      mode_ext   <= is_lmr && ba[0];
    end
  end

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    wire hit = ba[BA_W-1:0] == BA_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_open[i] <= 1'b0;
        rows[i]      <= '0;
      end else if (is_act && hit) begin
        bank_open[i] <= 1'b1;
        rows[i]      <= addr[ROW_W-1:0];
      end else if ((is_pre && (ap || hit)) || (access && ap && hit)) begin
        bank_open[i] <= 1'b0;
      end
    end
    assign open_rows[i*ROW_W +: ROW_W] = rows[i];
  end

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_desel, cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre,
              cmd_ref, cmd_bst, cmd_lmr, err_closed}));

  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> bank_open[bank_out] && rows[bank_out] == addr_out);

  a_r6_plain_access_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) && !auto_pre |-> bank_open[bank_out]);

  a_r7_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) && auto_pre |-> !bank_open[bank_out]);

  a_r9_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre && pre_all |-> bank_open == '0);

  a_r3_desel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_desel |-> $stable(bank_open) && $stable(open_rows));

  a_r11_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    err_closed |-> !cmd_rd && !cmd_wr && !auto_pre && $stable(bank_open));
endmodule

// File: tb/sdram_cmd_decode_bench.sv
module sdram_cmd_decode_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [10:0] addr = '0;
  logic cmd_desel, cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_bst, cmd_lmr;
  logic err_closed, auto_pre, pre_all, mode_ext;
  logic [1:0] bank_out;
  logic [10:0] addr_out;
  logic [7:0] col_out;
  logic [3:0] bank_open;
  logic [43:0] open_rows;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdram_cmd_decode u_sdram_cmd_decode (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_desel(cmd_desel), .cmd_nop(cmd_nop), .cmd_act(cmd_act),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref),
    .cmd_bst(cmd_bst), .cmd_lmr(cmd_lmr), .err_closed(err_closed), .bank_out(bank_out),
    .addr_out(addr_out), .col_out(col_out), .auto_pre(auto_pre), .pre_all(pre_all),
    .mode_ext(mode_ext), .bank_open(bank_open), .open_rows(open_rows));

  // behavioural reference: expected strobe vector order
  // {desel,nop,act,rd,wr,pre,ref,bst,lmr,err}
  bit [9:0] e_strb;
  bit [1:0] e_bank;
  bit [10:0] e_addr;
  bit e_ap, e_all, e_ext;
  bit e_open [4];
  int e_row [4];

  task automatic model_reset();
    e_strb = '0; e_bank = '0; e_addr = '0; e_ap = 0; e_all = 0; e_ext = 0;
    for (int i = 0; i < 4; i++) begin e_open[i] = 0; e_row[i] = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      e_bank = ba; e_addr = addr; e_ap = 0; e_all = 0; e_ext = 0; e_strb = '0;
      if (cs_n) e_strb[9] = 1;
      else begin
        case ({ras_n, cas_n, we_n})
          3'b111: e_strb[8] = 1;
          3'b011: begin e_strb[7] = 1; e_open[ba] = 1; e_row[ba] = addr; end
          3'b101, 3'b100: begin
            if (!e_open[ba]) e_strb[0] = 1;
            else begin
              if (we_n) e_strb[6] = 1; else e_strb[5] = 1;
              e_ap = addr[8];
              if (addr[8]) e_open[ba] = 0;
            end
          end
          3'b010: begin
            e_strb[4] = 1; e_all = addr[8];
            if (addr[8]) for (int i = 0; i < 4; i++) e_open[i] = 0;
            else e_open[ba] = 0;
          end
          3'b001: e_strb[3] = 1;
          3'b110: e_strb[2] = 1;
          default: begin e_strb[1] = 1; e_ext = ba[0]; end
        endcase
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [3:0] eo;
    bit [43:0] er;
    for (int i = 0; i < 4; i++) begin eo[i] = e_open[i]; er[i*11 +: 11] = 11'(e_row[i]); end
    chk("R4", "strobes", {cmd_desel, cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre,
        cmd_ref, cmd_bst, cmd_lmr, err_closed}, e_strb);
    chk("R11", "err_closed", err_closed, e_strb[0]);
    chk("R5", "bank_out/addr_out", {bank_out, addr_out}, {e_bank, e_addr});
    chk("R6", "col_out/auto_pre", {col_out, auto_pre}, {e_addr[7:0], e_ap});
    chk("R9", "pre_all", pre_all, e_all);
    chk("R10", "mode_ext", mode_ext, e_ext);
    chk("R12", "bank_open", bank_open, eo);
    chk("R7", "open_rows", open_rows, er);
  endtask

  always @(negedge clk) if (rst_n) compare_all();

  task automatic cmd(bit c, bit [2:0] k, bit [1:0] b, bit [10:0] a);
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = k; ba = b; addr = a;
  endtask

  localparam bit [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                       PRE = 3'b010, REF = 3'b001, BST = 3'b110, LMR = 3'b000;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "strobes in reset", {cmd_desel, cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre,
        cmd_ref, cmd_bst, cmd_lmr, err_closed}, 0);
    chk("R1", "banks in reset", {bank_open, open_rows}, 0);
    rst_n = 1'b1;
    chk("R1", "banks after release", bank_open, 0);
    // R11: access to closed banks
    cmd(0, RD, 2, 11'h005);
    cmd(0, WR, 1, 11'h105);
    // R5: open banks with distinct rows
    cmd(0, ACT, 0, 11'h7A5);
    cmd(0, ACT, 1, 11'h123);
    cmd(0, ACT, 2, 11'h456);
    cmd(0, ACT, 3, 11'h0F0);
    // R2: outputs hold on the edge only (checked at negedges by compare)
    cmd(0, RD, 0, 11'h033);
    cmd(0, WR, 3, 11'h0FF);
    // R7: auto precharge closes bank 1, then error on bank 1
    cmd(0, WR, 1, 11'h144);
    cmd(0, RD, 1, 11'h044);
    // R8: single precharge of bank 2, bank 3 stays open
    cmd(0, PRE, 2, 11'h000);
    cmd(0, WR, 2, 11'h010);
    cmd(0, RD, 3, 11'h011);
    // R12: no effect commands
    cmd(0, REF, 3, 11'h7FF);
    cmd(0, BST, 0, 11'h100);
    cmd(0, NOP, 0, 11'h100);
    // R10: both mode registers
    cmd(0, LMR, 0, 11'h032);
    cmd(0, LMR, 1, 11'h002);
    // R3: deselect with every code
    for (int k = 0; k < 8; k++) cmd(1, 3'(k), 2'(k), 11'h100);
    // R9: precharge all
    cmd(0, ACT, 1, 11'h3C3);
    cmd(0, PRE, 0, 11'h100);
    cmd(0, RD, 3, 11'h000);
    // random stream
    for (int n = 0; n < 3000; n++)
      cmd(($urandom % 8) == 0, 3'($urandom), 2'($urandom), 11'($urandom));
    cmd(0, NOP, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule